// File: doc/BRIEF.md
# UART Receive Buffer with Status

This block holds the bytes a UART receiver delivers until software collects them. A deserializer hands over one byte per cycle on a valid/data port, together with parity and framing flags. It can also signal a line break with a one-cycle pulse. Software takes bytes through a receive-data read strobe. The byte on offer is always visible on a read-data output, so the bus decode can return it in the same cycle as the strobe.

The block has two modes, chosen by a stored enable bit. In FIFO mode, bytes queue in a parameterised FIFO. In holding mode, each byte overwrites a single register. The block presents three status results:
- a packed FIFO status word;
- a sticky error status that clears when it is read;
- a data-ready flag.

It also emits one-cycle receive-event and error-event pulses for a separate interrupt unit. A small control write port sets the mode. The same port can empty the receive FIFO, and it can request a flush of the transmit side through a one-cycle pulse.

Top module: `uart_rx_store`

## Requirements
- R1: With control bit 0 (FIFO enable) clear, a received byte overwrites the holding register, `data_rdata` shows that register, `data_ready` is set the cycle after the byte, and a `data_rd` strobe clears `data_ready` at the next edge.
- R2: `fifo_status` carries the receive count in [7:0], receive-full in [8] with [7:0] forced to zero while the FIFO holds DEPTH entries, the OR of the error status bits in [9], `tx_level` in [23:16], `tx_full` in [24], and zero elsewhere.
- R3: In FIFO mode, a push sets `data_ready`; a read that takes the last entry without a push in the same cycle clears it; a read that leaves entries behind keeps it set.
- R4: In FIFO mode, `data_rdata` shows the oldest entry, a `data_rd` strobe removes it, and a push together with a read of a non-empty FIFO leaves the count unchanged.
- R5: In FIFO mode, a read of an empty FIFO presents 0x00 on `data_rdata` and pulses `err_evt` in the next cycle.
- R6: A push into a full FIFO without a read in the same cycle is dropped, sets the overrun bit (bit 0) of the error status, pulses `err_evt`, and sets `data_ready`; with a read in the same cycle it is stored.
- R7: `rx_break` stores a 0x00 byte (in the FIFO or the holding register, by mode), sets break bit 3 of the error status, and takes priority over `rx_valid` in the same cycle.
- R8: `rx_valid` with `rx_par_err` sets bit 1 and with `rx_frm_err` sets bit 2 of the error status and pulses `err_evt`; `err_rdata` shows the status, and an `err_rd` strobe clears it at the next edge except for bits set in that same cycle.
- R9: A control write stores bit 0; bit 1 empties the receive FIFO and clears `data_ready` (winning over a push or read in that cycle); bit 2 gives a one-cycle `tx_flush` pulse; bits 1 and 2 always read back 0 on `ctl_rdata`.
- R10: `rx_evt` pulses for one cycle after every cycle with `rx_valid` or `rx_break` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control data: [0] FIFO enable, [1] receive flush, [2] transmit flush |
| ctl_rdata | output | 3 | Control readback, flush bits read 0 |
| tx_flush | output | 1 | One-cycle transmit flush request |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error flag for the byte |
| rx_frm_err | input | 1 | Framing error flag for the byte |
| rx_break | input | 1 | Break event pulse |
| data_rd | input | 1 | Receive-data read strobe |
| data_rdata | output | 8 | Byte on offer to a read |
| err_rd | input | 1 | Error status read strobe (clear on read) |
| err_rdata | output | 4 | Error status: [0] overrun, [1] parity, [2] frame, [3] break |
| tx_level | input | 8 | Transmit FIFO count from the transmit side |
| tx_full | input | 1 | Transmit FIFO full from the transmit side |
| fifo_status | output | 32 | Packed FIFO status word |
| data_ready | output | 1 | Receive data available |
| rx_evt | output | 1 | Receive event pulse |
| err_evt | output | 1 | Error event pulse |

## Verification
Every result in this block is due one edge after its stimulus. `data_ready`, `rx_evt`, `err_evt` and `tx_flush` are registers. `fifo_status`, `data_rdata` and `err_rdata` are decoded from state that the same edge updates, apart from the transmit fields, which follow their inputs directly. The bench drives inputs just after a falling edge and advances a queue-based reference model by one step. It then waits for the next falling edge and compares all outputs against the model, so every comparison lands exactly one rising edge after the stimulus it depends on.

// File: rtl/uart_rx_store_pkg.sv
// Shared constants and types for the UART receive buffer.
// Assumes byte-wide serial data and a four-bit error status.
package uart_rx_store_pkg;
    localparam int BYTE_W = 8;
    localparam int ERR_W  = 4;
    localparam int CTL_W  = 3;

    // Control word bit positions
    localparam int CTL_FIFO_EN  = 0;
    localparam int CTL_RX_FLUSH = 1;
    localparam int CTL_TX_FLUSH = 2;

    // Error status, packed so bit 0 is overrun and bit 3 is break
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } err_flags_t;
endpackage

// File: rtl/rxs_fifo.sv
// Circular byte FIFO with an occupancy counter.
// Assumes DEPTH >= 2. Flush wins over push and pop. A push into a full
// FIFO is accepted only if a pop of a stored entry occurs in the same cycle.
module rxs_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [W-1:0]     data_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             drop_o
);
    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign pop_ok  = pop_i && !empty_o && !flush_i;
    assign push_ok = push_i && !flush_i && (!full_o || pop_ok);
    assign drop_o  = push_i && !flush_i && full_o && !pop_ok;
    assign head_o  = slot_q[rptr_q];
    assign count_o = cnt_q;

    // Storage write: data slots carry no reset
    always_ff @(posedge clk) begin
        if (push_ok) slot_q[wptr_q] <= data_i;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wptr_q <= ptr_inc(wptr_q);
            if (pop_ok)  rptr_q <= ptr_inc(rptr_q);
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R4
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o && !flush_i) |=> (count_o == $past(count_o)));
    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i && !flush_i) |=> full_o);
    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));
endmodule

// File: rtl/rxs_errstat.sv
// Sticky receive error status with clear-on-read.
// Assumes the read strobe lasts one cycle; bits set in the clearing cycle stay.
module rxs_errstat
    import uart_rx_store_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  err_flags_t set_i,
    input  logic       clr_i,
    output err_flags_t stat_o
);
    err_flags_t stat_q;

    // Accumulate new flags over the old value, or over zero after a read
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (clr_i ? err_flags_t'('0) : stat_q) | set_i;
    end

    assign stat_o = stat_q;

    // R8
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (stat_o == '0));
    // R7
    break_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i.brk |=> stat_o.brk);
endmodule

// File: rtl/uart_rx_store.sv
// Receive-side storage of a UART: FIFO or single holding register,
// packed FIFO status, clear-on-read error status, data-ready flag and
// event pulses for an interrupt unit. Assumes one-cycle read and write
// strobes from an external bus decode and DEPTH <= 256.
module uart_rx_store
    import uart_rx_store_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic              tx_flush,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_break,
    input  logic              data_rd,
    output logic [BYTE_W-1:0] data_rdata,
    input  logic              err_rd,
    output logic [ERR_W-1:0]  err_rdata,
    input  logic [7:0]        tx_level,
    input  logic              tx_full,
    output logic [31:0]       fifo_status,
    output logic              data_ready,
    output logic              rx_evt,
    output logic              err_evt
);
    logic              fifo_en_q, tx_flush_q, rdy_q, rx_evt_q, err_evt_q;
    logic [BYTE_W-1:0] hold_q;
    logic              push_en, rx_flush, fifo_push, fifo_pop, empty_rd;
    logic [BYTE_W-1:0] push_byte, fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full, fifo_empty, fifo_drop;
    err_flags_t        err_set, err_stat;

    assign push_en   = rx_valid || rx_break;
    assign push_byte = rx_break ? '0 : rx_data;
    assign rx_flush  = ctl_wr && ctl_wdata[CTL_RX_FLUSH];
    assign fifo_push = fifo_en_q && push_en;
    assign fifo_pop  = fifo_en_q && data_rd;
    assign empty_rd  = fifo_en_q && data_rd && fifo_empty;

    rxs_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush_i(rx_flush),
        .push_i (fifo_push),
        .data_i (push_byte),
        .pop_i  (fifo_pop),
        .head_o (fifo_head),
        .count_o(fifo_cnt),
        .full_o (fifo_full),
        .empty_o(fifo_empty),
        .drop_o (fifo_drop)
    );

    // Gather error flags raised this cycle
    always_comb begin
        err_set     = '0;
        err_set.ovr = fifo_drop;
        err_set.par = rx_valid && !rx_break && rx_par_err;
        err_set.frm = rx_valid && !rx_break && rx_frm_err;
        err_set.brk = rx_break;
    end

    rxs_errstat u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_set),
        .clr_i (err_rd),
        .stat_o(err_stat)
    );

    // Control bit storage and the transmit flush pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en_q  <= 1'b0;
            tx_flush_q <= 1'b0;
        end else begin
            if (ctl_wr) fifo_en_q <= ctl_wdata[CTL_FIFO_EN];
            tx_flush_q <= ctl_wr && ctl_wdata[CTL_TX_FLUSH];
        end
    end

    // Holding register for non-FIFO mode
    always_ff @(posedge clk) begin
        if (!rst_n)                      hold_q <= '0;
        else if (!fifo_en_q && push_en)  hold_q <= push_byte;
    end

    // Data-ready flag: set on arrival, cleared by draining read or flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
        end else if (rx_flush) begin
            rdy_q <= 1'b0;
        end else if (push_en) begin
            rdy_q <= 1'b1;
        end else if (fifo_en_q) begin
            if (data_rd && fifo_cnt == CNT_W'(1)) rdy_q <= 1'b0;
        end else if (data_rd) begin
            rdy_q <= 1'b0;
        end
    end

    // Event pulses for the interrupt unit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_evt_q  <= 1'b0;
            err_evt_q <= 1'b0;
        end else begin
            rx_evt_q  <= push_en;
            err_evt_q <= fifo_drop || empty_rd || err_set.par || err_set.frm;
        end
    end

    // Status word packing; count reads zero when full
    always_comb begin
        fifo_status        = '0;
        fifo_status[7:0]   = fifo_full ? 8'd0 : 8'(fifo_cnt);
        fifo_status[8]     = fifo_full;
        fifo_status[9]     = |err_stat;
        fifo_status[23:16] = tx_level;
        fifo_status[24]    = tx_full;
    end

    assign data_rdata = fifo_en_q ? (fifo_empty ? '0 : fifo_head) : hold_q;
    assign err_rdata  = err_stat;
    assign ctl_rdata  = {2'b00, fifo_en_q};
    assign tx_flush   = tx_flush_q;
    assign data_ready = rdy_q;
    assign rx_evt     = rx_evt_q;
    assign err_evt    = err_evt_q;

    // R10
    rx_evt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> rx_evt);
    // R3
    last_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en_q && data_rd && fifo_cnt == CNT_W'(1) && !push_en && !rx_flush)
        |=> !data_ready);
    // R5
    empty_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rd |=> err_evt);
    // R1
    hold_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en_q && data_rd && !push_en) |=> !data_ready);
    // R9
    tx_flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> !tx_flush || $past(ctl_wr));
endmodule

// File: tb/tb_uart_rx_store.sv
// Bench for uart_rx_store: a behavioural queue model steps once per cycle
// and every output is compared on each falling edge.
module tb_uart_rx_store;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 0;
    logic [2:0] ctl_wdata = 0;
    logic [2:0] ctl_rdata;
    logic       tx_flush;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       rx_par_err = 0, rx_frm_err = 0, rx_break = 0;
    logic       data_rd = 0;
    logic [7:0] data_rdata;
    logic       err_rd = 0;
    logic [3:0] err_rdata;
    logic [7:0] tx_level = 0;
    logic       tx_full = 0;
    logic [31:0] fifo_status;
    logic       data_ready, rx_evt, err_evt;

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [7:0] m_q[$];
    logic [7:0] m_hold = 0;
    logic       m_rdy = 0, m_fen = 0, m_rxevt = 0, m_errevt = 0, m_txfl = 0;
    logic [3:0] m_err = 0;

    uart_rx_store #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .tx_flush(tx_flush), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .rx_break(rx_break), .data_rd(data_rd), .data_rdata(data_rdata),
        .err_rd(err_rd), .err_rdata(err_rdata), .tx_level(tx_level),
        .tx_full(tx_full), .fifo_status(fifo_status), .data_ready(data_ready),
        .rx_evt(rx_evt), .err_evt(err_evt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        if (m_q.size() == DEPTH) s[8] = 1'b1;
        else                     s[7:0] = 8'(m_q.size());
        s[9]     = |m_err;
        s[23:16] = tx_level;
        s[24]    = tx_full;
        return s;
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (!m_fen) return m_hold;
        return (m_q.size() > 0) ? m_q[0] : 8'h00;
    endfunction

    // One model step from the inputs currently driven
    task automatic model_step();
        logic       pushen = rx_valid || rx_break;
        logic [7:0] byt    = rx_break ? 8'h00 : rx_data;
        logic       flush  = ctl_wr && ctl_wdata[1];
        logic       drop = 0, emptyrd = 0, par, frm;
        int         pre  = m_q.size();
        par = rx_valid && !rx_break && rx_par_err;
        frm = rx_valid && !rx_break && rx_frm_err;
        if (m_fen) begin
            emptyrd = data_rd && (pre == 0);
            if (flush) m_q.delete();
            else begin
                if (data_rd && pre > 0) void'(m_q.pop_front());
                if (pushen) begin
                    if (pre < DEPTH || (data_rd && pre > 0)) m_q.push_back(byt);
                    else drop = 1;
                end
            end
            if (pushen) m_rdy = 1;
            else if (data_rd && pre == 1) m_rdy = 0;
        end else begin
            if (pushen) begin m_hold = byt; m_rdy = 1; end
            else if (data_rd) m_rdy = 0;
            if (flush) m_q.delete();
        end
        if (flush) m_rdy = 0;
        m_err    = (err_rd ? 4'h0 : m_err) | {rx_break, frm, par, drop};
        m_rxevt  = pushen;
        m_errevt = drop || emptyrd || par || frm;
        m_txfl   = ctl_wr && ctl_wdata[2];
        if (ctl_wr) m_fen = ctl_wdata[0];
    endtask

    task automatic compare();
        chk("R2 fifo_status", fifo_status, exp_status());
        chk("R1/R4 data_rdata", {24'h0, data_rdata}, {24'h0, exp_rdata()});
        chk("R3 data_ready", {31'h0, data_ready}, {31'h0, m_rdy});
        chk("R8 err_rdata", {28'h0, err_rdata}, {28'h0, m_err});
        chk("R10 rx_evt", {31'h0, rx_evt}, {31'h0, m_rxevt});
        chk("R5 err_evt", {31'h0, err_evt}, {31'h0, m_errevt});
        chk("R9 ctl_rdata", {29'h0, ctl_rdata}, {29'h0, 2'b00, m_fen});
        chk("R9 tx_flush", {31'h0, tx_flush}, {31'h0, m_txfl});
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare();
        ctl_wr = 0; ctl_wdata = 0; rx_valid = 0; rx_data = 0;
        rx_par_err = 0; rx_frm_err = 0; rx_break = 0; data_rd = 0; err_rd = 0;
    endtask

    task automatic rx(input logic [7:0] b);
        rx_valid = 1; rx_data = b; tick();
    endtask

    task automatic rd();
        data_rd = 1; tick();
    endtask

    task automatic ctl(input logic [2:0] w);
        ctl_wr = 1; ctl_wdata = w; tick();
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // Reset state on every output
        tick();
        tick();

        // R1: holding mode overwrite and read clear
        rx(8'h41);
        rx(8'h42);
        rd();
        tick();

        // R7: break in holding mode beats a simultaneous byte
        rx_valid = 1; rx_data = 8'h77; rx_break = 1; tick();
        // R8: clear on read, then set-in-clear-cycle survives
        err_rd = 1; tick();
        rx_valid = 1; rx_data = 8'h10; rx_par_err = 1; tick();
        err_rd = 1; rx_valid = 1; rx_data = 8'h11; rx_frm_err = 1; tick();
        err_rd = 1; tick();

        // R9: enable FIFO mode
        ctl(3'b001);
        // R4: order, push and pop together
        rx(8'hA1); rx(8'hA2); rx(8'hA3);
        rd();
        data_rd = 1; rx_valid = 1; rx_data = 8'hA4; tick();
        // R3: reads leaving data keep ready, last read clears
        rd(); rd(); rd();
        // R5: empty FIFO read gives zero and an error event
        rd();
        tick();

        // R6: fill, overflow drop, push with pop at full
        tx_level = 8'h5A; tx_full = 1;
        for (int i = 0; i < DEPTH; i++) rx(8'(8'h30 + i));
        rx(8'hEE);
        err_rd = 1; tick();
        data_rd = 1; rx_valid = 1; rx_data = 8'hEF; tick();
        tx_level = 8'h03; tx_full = 0;
        // R9: receive flush wins over a push in the same cycle
        ctl_wr = 1; ctl_wdata = 3'b011; rx_valid = 1; rx_data = 8'h99; tick();
        // R7: break in FIFO mode stores zero
        rx_break = 1; tick();
        rd();
        // R9: transmit flush pulse and self-clearing bits
        ctl(3'b101);
        tick();

        // Mixed traffic in FIFO mode
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rx_valid   = lfsr[0] | lfsr[1];
            rx_data    = lfsr[15:8];
            rx_par_err = lfsr[2] & lfsr[3] & lfsr[4];
            rx_frm_err = lfsr[5] & lfsr[6] & lfsr[7];
            rx_break   = (lfsr[11:8] == 4'h0);
            data_rd    = lfsr[2] & lfsr[9];
            err_rd     = lfsr[12] & lfsr[13];
            if (lfsr[15:10] == 6'h3F) begin ctl_wr = 1; ctl_wdata = 3'b011; end
            tick();
        end
        // Drain back to holding mode
        ctl(3'b000);
        rx(8'h5C);
        rd();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule